// File: doc/BRIEF.md
# Shared-Load Shift Chain Master Sequencer

This block drives one serial daisy chain made of output latch registers followed by parallel-load input registers. The chain sees only three controller lines: a shift clock, a single shift/load strobe and serial data out. The chain's last stage returns on a serial data-in pin. One strobe latches every output and captures every input in the same pulse.

A transaction starts with a one-cycle start request. If the update flag is set, the presented output word first replaces a shadow register. The sequencer then clocks the shadow contents into the chain, most significant bit first, while the strobe is held high. It drops the strobe for one divided clock period and raises it again. It then clocks the chain once per input bit and collects the captured inputs into a result register. Done then pulses. A read-only request works the same way with the flag clear. Because the chain shares the strobe, the unchanged shadow contents are re-sent so that the outputs keep their values.

The output width, input width and clock divider are parameters. The defaults are 64 output bits and 16 input bits, which suits eight 7-segment digits and a keypad.

Top module: `shift_chain_master`

## Requirements
- R1: After reset, busy and done are 0, chain_clk is 0, chain_load is 1 and in_data is all zeros.
- R2: A start while idle makes busy 1 on the next cycle. When upd is 1 at that start, wr_data becomes the new shadow output word.
- R3: The shadow word goes out on chain_dout MSB first, one bit per chain_clk rising edge, with exactly OUT_BITS rising edges before the strobe. chain_load is high at every rising edge, and chain_dout holds steady while chain_clk is high.
- R4: After the output phase, chain_load goes low exactly once per transaction for 2*HALF_DIV system cycles. chain_clk stays low for that whole time.
- R5: After the strobe returns high, exactly IN_BITS further chain_clk rising edges occur. chain_din is sampled just before each one. The first sampled bit (the stage nearest the controller) ends in in_data[IN_BITS-1] and the last one in in_data[0].
- R6: A start with upd 0 re-sends the current shadow word, so the chain's latched outputs keep their previous values while fresh inputs are collected.
- R7: A start while busy has no effect: the running transaction completes unchanged, no extra transaction follows, and its wr_data does not enter the shadow word.
- R8: done is high for exactly one cycle, in the cycle in_data takes its new value, and busy is 0 in that cycle.
- R9: While idle, chain_clk is 0 and chain_load is 1.
- R10: Each chain_clk period lasts 2*HALF_DIV system cycles, and a transaction makes exactly OUT_BITS+IN_BITS rising edges in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transaction request |
| upd | input | 1 | With start: load wr_data into the shadow word first |
| wr_data | input | OUT_BITS | New output word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when in_data is updated |
| in_data | output | IN_BITS | Collected input bits |
| chain_clk | output | 1 | Shift clock to the chain |
| chain_load | output | 1 | Shared strobe, low to latch outputs and capture inputs |
| chain_dout | output | 1 | Serial data into the chain |
| chain_din | input | 1 | Serial data from the chain's last stage |

## Verification
The bench builds the block with 16 output bits, 8 input bits and a half-period divider of 2. A transaction therefore takes about a hundred cycles, and many patterns fit in a short run. The bench's behavioural chain latches on the falling edge of the strobe and loads a keypad word into its last stages. This exposes bit order in both directions, the count of clock edges in each phase, and the exact strobe width. Single-bit patterns at both ends of the word, along with all-ones and all-zeros frames, separate MSB-first ordering from any reversal.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SH_LO,
    S_SH_HI,
    S_LOAD,
    S_RD_LO,
    S_RD_HI
  } scm_state_e;
endpackage

// File: rtl/scm_pacer.sv
// Half-period tick generator for the chain clock.
module scm_pacer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = $clog2(HALF_DIV) + 1;
  localparam logic [PW-1:0] LAST = PW'(HALF_DIV - 1);

  logic [PW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scm_out_shifter.sv
// Shadow output word and the MSB-first serialiser.
module scm_out_shifter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic         upd,
  input  logic [W-1:0] wr_data,
  input  logic         shift_en,
  output logic         serial_out
);
  logic [W-1:0] shadow;
  logic [W-1:0] sreg;

  assign serial_out = sreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      sreg   <= '0;
    end else if (load_en) begin
      if (upd) shadow <= wr_data;
      sreg <= upd ? wr_data : shadow;
    end else if (shift_en) begin
      sreg <= {sreg[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/scm_in_collector.sv
// Deserialiser for returned input bits; first sample ends in the MSB.
module scm_in_collector #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_en,
  input  logic         serial_in,
  input  logic         commit,
  output logic [W-1:0] result
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      result <= '0;
    end else begin
      if (sample_en) sreg   <= {sreg[W-2:0], serial_in};
      if (commit)    result <= sreg;
    end
  end
endmodule

// File: rtl/shift_chain_master.sv
module shift_chain_master
  import scm_pkg::*;
#(
  parameter int OUT_BITS = 64,
  parameter int IN_BITS  = 16,
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                upd,
  input  logic [OUT_BITS-1:0] wr_data,
  output logic                busy,
  output logic                done,
  output logic [IN_BITS-1:0]  in_data,
  output logic                chain_clk,
  output logic                chain_load,
  output logic                chain_dout,
  input  logic                chain_din
);
  localparam int MAXB = (OUT_BITS > IN_BITS) ? OUT_BITS : IN_BITS;
  localparam int CW   = $clog2(MAXB) + 1;
  localparam logic [CW-1:0] OUT_LAST = CW'(OUT_BITS - 1);
  localparam logic [CW-1:0] IN_LAST  = CW'(IN_BITS - 1);

  scm_state_e    state;
  logic [CW-1:0] bitcnt;
  logic          ld_half;
  logic          tick;
  logic          accept;
  logic          shift_en;
  logic          sample_en;
  logic          commit;

  assign accept    = start && (state == S_IDLE);
  assign shift_en  = tick && (state == S_SH_HI);
  assign sample_en = tick && (state == S_RD_LO);
  assign commit    = tick && (state == S_RD_HI) && (bitcnt == IN_LAST);

  scm_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
    .clk  (clk),
    .rst  (rst),
    .run  (state != S_IDLE),
    .tick (tick)
  );

  scm_out_shifter #(.W(OUT_BITS)) u_out (
    .clk        (clk),
    .rst        (rst),
    .load_en    (accept),
    .upd        (upd),
    .wr_data    (wr_data),
    .shift_en   (shift_en),
    .serial_out (chain_dout)
  );

  scm_in_collector #(.W(IN_BITS)) u_in (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .serial_in (chain_din),
    .commit    (commit),
    .result    (in_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      bitcnt     <= '0;
      ld_half    <= 1'b0;
      chain_clk  <= 1'b0;
      chain_load <= 1'b1;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_SH_LO;
            busy   <= 1'b1;
            bitcnt <= '0;
          end
        end
        S_SH_LO: begin
          if (tick) begin
            chain_clk <= 1'b1;
            state     <= S_SH_HI;
          end
        end
        S_SH_HI: begin
          if (tick) begin
            chain_clk <= 1'b0;
            if (bitcnt == OUT_LAST) begin
              bitcnt     <= '0;
              chain_load <= 1'b0;
              ld_half    <= 1'b0;
              state      <= S_LOAD;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              state  <= S_SH_LO;
            end
          end
        end
        S_LOAD: begin
          if (tick) begin
            if (!ld_half) begin
              ld_half <= 1'b1;
            end else begin
              chain_load <= 1'b1;
              state      <= S_RD_LO;
            end
          end
        end
        S_RD_LO: begin
          if (tick) begin
            chain_clk <= 1'b1;
            state     <= S_RD_HI;
          end
        end
        S_RD_HI: begin
          if (tick) begin
            chain_clk <= 1'b0;
            if (bitcnt == IN_LAST) begin
              state <= S_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              state  <= S_RD_LO;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scm_checker.sv
module scm_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic chain_clk,
  input logic chain_load,
  input logic chain_dout
);
  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!chain_clk && chain_load));

  // R3
  load_high_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(chain_clk) |-> chain_load);

  // R3
  dout_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (chain_clk && $past(chain_clk)) |-> $stable(chain_dout));

  // R4
  clk_low_in_load_chk: assert property (@(posedge clk) disable iff (rst)
    !chain_load |-> !chain_clk);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

bind shift_chain_master scm_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .chain_clk  (chain_clk),
  .chain_load (chain_load),
  .chain_dout (chain_dout)
);

// File: tb/sim_shift_chain_master.sv
`timescale 1ns/1ps
module sim_shift_chain_master;
  localparam int OW = 16;
  localparam int IW = 8;
  localparam int HD = 2;
  localparam int NB = OW + IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          upd = 1'b0;
  logic [OW-1:0] wr_data = '0;
  logic          busy, done;
  logic [IW-1:0] in_data;
  logic          chain_clk, chain_load, chain_dout, chain_din;

  always #2.5 clk = ~clk;

  shift_chain_master #(.OUT_BITS(OW), .IN_BITS(IW), .HALF_DIV(HD)) u0 (
    .clk(clk), .rst(rst), .start(start), .upd(upd), .wr_data(wr_data),
    .busy(busy), .done(done), .in_data(in_data),
    .chain_clk(chain_clk), .chain_load(chain_load),
    .chain_dout(chain_dout), .chain_din(chain_din)
  );

  // Behavioural chain: stage 0 nearest chain_dout, stage NB-1 drives chain_din.
  logic [NB-1:0] chain = '0;
  logic [OW-1:0] latched = '0;
  logic [IW-1:0] sw_model = '0;
  assign chain_din = chain[NB-1];

  always @(posedge chain_clk or negedge chain_load) begin
    if (!chain_load) begin
      latched        <= chain[OW-1:0];
      chain[NB-1:OW] <= sw_model;
    end else begin
      chain <= {chain[NB-2:0], chain_dout};
    end
  end

  int rises = 0, rises_ld_low = 0, loads = 0, low_cyc = 0, done_cyc = 0;
  always @(posedge chain_clk) begin
    rises++;
    if (!chain_load) rises_ld_low++;
  end
  always @(negedge chain_load) loads++;
  always @(posedge clk) begin
    if (!rst && !chain_load) low_cyc++;
    if (!rst && done) done_cyc++;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic u, input logic [OW-1:0] d, input logic [IW-1:0] sw);
    sw_model = sw;
    @(negedge clk);
    start = 1'b1; upd = u; wr_data = d;
    @(negedge clk);
    start = 1'b0; upd = 1'b0;
    chk("R2", "busy after start", busy, 1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R8", "done seen", done, 1);
    chk("R8", "busy low with done", busy, 0);
  endtask

  task automatic txn(input logic u, input logic [OW-1:0] d, input logic [IW-1:0] sw,
                     input logic [OW-1:0] exp_out, input string req);
    int r0 = rises, rl0 = rises_ld_low, l0 = loads, w0 = low_cyc, d0 = done_cyc;
    launch(u, d, sw);
    wait_done();
    chk("R5", "in_data", in_data, sw);
    chk(req, "latched outputs", latched, exp_out);
    @(negedge clk);
    chk("R8", "done one cycle", done, 0);
    chk("R8", "done count", done_cyc - d0, 1);
    chk("R10", "clock rises", rises - r0, NB);
    chk("R3", "rises with load low", rises_ld_low - rl0, 0);
    chk("R4", "load pulses", loads - l0, 1);
    chk("R4", "load low cycles", low_cyc - w0, 2 * HD);
    chk("R9", "idle clk", chain_clk, 0);
    chk("R9", "idle load", chain_load, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "chain_clk", chain_clk, 0);
    chk("R1", "chain_load", chain_load, 1);
    chk("R1", "in_data", in_data, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_period();
    // R10: one chain clock period is 2*HD system cycles
    int a = 0, b = 0, n = 0;
    launch(1'b1, 16'h1234, 8'h00);
    while (!chain_clk && n < 100) begin @(negedge clk); n++; end
    while (chain_clk && n < 100) begin @(negedge clk); n++; end
    while (!chain_clk && n < 100) begin @(negedge clk); n++; a++; end
    while (chain_clk && n < 100) begin @(negedge clk); n++; b++; end
    chk("R10", "clock period", a + b, 2 * HD);
    wait_done();
    chk("R3", "latched after period test", latched, 16'h1234);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    int r0;
    launch(1'b1, 16'h0F0F, 8'h69);
    repeat (30) @(negedge clk);
    start = 1'b1; upd = 1'b1; wr_data = 16'hFFFF;
    @(negedge clk);
    start = 1'b0; upd = 1'b0;
    wait_done();
    chk("R7", "outputs unchanged by busy start", latched, 16'h0F0F);
    chk("R7", "in_data", in_data, 8'h69);
    r0 = rises;
    repeat (20) @(negedge clk);
    chk("R7", "no extra transaction", rises - r0, 0);
    chk("R7", "busy stays low", busy, 0);
    txn(1'b0, 16'h0000, 8'h11, 16'h0F0F, "R7");
  endtask

  initial begin
    t_reset();
    txn(1'b1, 16'hA5C3, 8'h5A, 16'hA5C3, "R3");
    txn(1'b1, 16'h8001, 8'h81, 16'h8001, "R3");
    txn(1'b1, 16'h8000, 8'h80, 16'h8000, "R3");
    txn(1'b1, 16'h0001, 8'h01, 16'h0001, "R3");
    txn(1'b0, 16'h7777, 8'h3C, 16'h0001, "R6");
    txn(1'b1, 16'hFFFF, 8'hFF, 16'hFFFF, "R2");
    txn(1'b1, 16'h0000, 8'h00, 16'h0000, "R2");
    txn(1'b0, 16'hFFFF, 8'hC3, 16'h0000, "R6");
    t_period();
    t_busy_ignore();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule